// File: doc/BRIEF.md
# Lockable Configuration Register Bank

This block is a small byte-wide register file. A host writes it and reads it over a plain bus: an address, a data byte, a one-cycle write strobe and a read-data return. The stored configuration is also driven straight out as decoded control pins for the rest of the chip. Each register carries a fixed lockable attribute.

A control register holds a one-way lock flag. Once that flag is set, every register marked lockable refuses host writes until the next reset. A refused write gives the host no error. The store just keeps its old value.

The bank also answers at two test locations and at every unmapped address. These locations always read zero and nothing written there is kept. Bits that have no function read back as zero whatever data is written to them.

The bus is a register bus and not a data stream. It has no valid/ready handshake and never applies back-pressure. A write is taken on every clock edge where the strobe is high. Read data is a combinational function of the address and the current register contents.

Top module: `cfg_lock_bank`

## Requirements
- R1: After reset, every register reads 0x00 and every decoded output pin is 0.
- R2: While unlocked, a write to a mapped register takes effect at the clock edge where the strobe is high. From the next cycle, its writable bits read back with the written value and drive the decoded outputs.
- R3: While the lock flag is 1, writes to the lockable registers are ignored: smoothing (0x10), hysteresis (0x11) and bypass (0x7D). Their contents and outputs do not change.
- R4: Writing a 1 to bit 1 of the control register (0x40) sets the lock flag, which reads back on that bit and on the `locked` pin. Writing 0 to that bit leaves the flag set. Only reset clears it.
- R5: The scratch register (0x30) and the run bit (bit 0 of 0x40) are not lockable and stay writable after the lock flag is set.
- R6: The test locations 0x7E and 0x7F, and every address not listed here, read 0x00 and keep nothing that is written to them.
- R7: In the hysteresis register only bit 0 is writable, and bits 7:1 read 0. In the control register bits 7:2 read 0.
- R8: The smoothing register 0x10 drives its fields in this bit order. Bits 2:0 are the slow-smoothing enables of channels 0, 1 and 2. Bit 3 is the over-temperature-in-manual enable. Bit 4 is the fan-sync follower enable and bit 5 the fan-sync leader enable. Bit 6 is the core-supply-low enable and bit 7 is the extra-slow enable.
- R9: `bypass_cfg` equals register 0x7D, `run_en` equals bit 0 of 0x40, and `hyst_disable` equals bit 0 of 0x11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| slow_smooth | output | 3 | Per-channel slow-smoothing enables |
| therm_manual | output | 1 | Over-temperature response enabled in manual mode |
| sync_slave | output | 1 | Fan-sync follower enable |
| sync_master | output | 1 | Fan-sync leader enable |
| core_low_en | output | 1 | Core-supply-low handling enable |
| extra_slow | output | 1 | Extra-slow smoothing enable |
| hyst_disable | output | 1 | Disable over-temperature hysteresis |
| run_en | output | 1 | Run bit of the control register |
| bypass_cfg | output | 8 | Bypass configuration byte |
| locked | output | 1 | Lock flag |

## Verification
A corrupted register shows on the decoded pins one cycle after the faulty edge. It shows on `bus_rdata` as soon as the bench places that address on the bus. The bench therefore compares every output pin and the current read data against its own model on every cycle.

A lock flag that drops early or sets late is caught on the first later write to a lockable register. A missing write mask is caught on the first read-back of the hysteresis register, the control register or a test location.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
  localparam int BANK_AW   = 8;
  localparam int BANK_DW   = 8;
  localparam int NUM_SLOTS = 5;

  typedef logic [BANK_AW-1:0] addr_t;
  typedef logic [BANK_DW-1:0] data_t;

  localparam addr_t ADDR_SMOOTH  = 8'h10;
  localparam addr_t ADDR_HYST    = 8'h11;
  localparam addr_t ADDR_SCRATCH = 8'h30;
  localparam addr_t ADDR_CTRL    = 8'h40;
  localparam addr_t ADDR_BYPASS  = 8'h7D;
  localparam addr_t ADDR_TEST_A  = 8'h7E;
  localparam addr_t ADDR_TEST_B  = 8'h7F;

  localparam int SLOT_SMOOTH  = 0;
  localparam int SLOT_HYST    = 1;
  localparam int SLOT_SCRATCH = 2;
  localparam int SLOT_CTRL    = 3;
  localparam int SLOT_BYPASS  = 4;

  localparam int RUN_BIT  = 0;
  localparam int LOCK_BIT = 1;

  function automatic addr_t slot_addr(int idx);
    case (idx)
      SLOT_SMOOTH:  return ADDR_SMOOTH;
      SLOT_HYST:    return ADDR_HYST;
      SLOT_SCRATCH: return ADDR_SCRATCH;
      SLOT_CTRL:    return ADDR_CTRL;
      default:      return ADDR_BYPASS;
    endcase
  endfunction

  function automatic data_t slot_mask(int idx);
    case (idx)
      SLOT_HYST: return data_t'(1);
      SLOT_CTRL: return data_t'(1) << RUN_BIT;
      default:   return '1;
    endcase
  endfunction

  function automatic bit slot_lockable(int idx);
    return (idx == SLOT_SMOOTH) || (idx == SLOT_HYST) || (idx == SLOT_BYPASS);
  endfunction
endpackage

// File: rtl/cfg_reg_slot.sv
module cfg_reg_slot
  import cfg_bank_pkg::*;
#(
  parameter addr_t ADDR     = 8'h00,
  parameter data_t MASK     = '1,
  parameter bit    LOCKABLE = 1'b0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  addr_t addr,
  input  data_t wdata,
  input  logic  locked,
  output data_t q
);
  logic hit, accept;

  assign hit = wr_en && (addr == ADDR);

  generate
    if (LOCKABLE) begin : g_guarded
      assign accept = hit && !locked;
    end else begin : g_open
      assign accept = hit;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (accept) q <= wdata & MASK;
  end

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !(LOCKABLE && locked)) |=> (q == ($past(wdata) & MASK)));

  generate
    if (LOCKABLE) begin : g_lock_chk
      p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(q));
    end
  endgenerate
endmodule

// File: rtl/cfg_lock_flag.sv
module cfg_lock_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  output logic locked
);
  always_ff @(posedge clk) begin
    if (!rst_n)       locked <= 1'b0;
    else if (set_req) locked <= 1'b1;
  end

  p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  p_lock_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> locked);
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import cfg_bank_pkg::*;
(
  input  addr_t addr,
  input  data_t slot_q [NUM_SLOTS],
  input  logic  locked,
  output data_t rdata
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (addr == slot_addr(i)) rdata = slot_q[i];
    end
    if (addr == ADDR_CTRL) rdata[LOCK_BIT] = locked;
  end
endmodule

// File: rtl/cfg_lock_bank.sv
module cfg_lock_bank
  import cfg_bank_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_wr,
  output logic [7:0] bus_rdata,
  output logic [2:0] slow_smooth,
  output logic       therm_manual,
  output logic       sync_slave,
  output logic       sync_master,
  output logic       core_low_en,
  output logic       extra_slow,
  output logic       hyst_disable,
  output logic       run_en,
  output logic [7:0] bypass_cfg,
  output logic       locked
);
  data_t slot_q [NUM_SLOTS];
  logic  lock_q;
  logic  lock_req;

  generate
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      cfg_reg_slot #(
        .ADDR     (slot_addr(s)),
        .MASK     (slot_mask(s)),
        .LOCKABLE (slot_lockable(s))
      ) i_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .locked (lock_q),
        .q      (slot_q[s])
      );
    end
  endgenerate

  assign lock_req = bus_wr && (bus_addr == ADDR_CTRL) && bus_wdata[LOCK_BIT];

  cfg_lock_flag i_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (lock_req),
    .locked  (lock_q)
  );

  cfg_read_mux i_rmux (
    .addr   (bus_addr),
    .slot_q (slot_q),
    .locked (lock_q),
    .rdata  (bus_rdata)
  );

  assign slow_smooth  = slot_q[SLOT_SMOOTH][2:0];
  assign therm_manual = slot_q[SLOT_SMOOTH][3];
  assign sync_slave   = slot_q[SLOT_SMOOTH][4];
  assign sync_master  = slot_q[SLOT_SMOOTH][5];
  assign core_low_en  = slot_q[SLOT_SMOOTH][6];
  assign extra_slow   = slot_q[SLOT_SMOOTH][7];
  assign hyst_disable = slot_q[SLOT_HYST][0];
  assign run_en       = slot_q[SLOT_CTRL][RUN_BIT];
  assign bypass_cfg   = slot_q[SLOT_BYPASS];
  assign locked       = lock_q;

  p_test_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_addr == ADDR_TEST_A) || (bus_addr == ADDR_TEST_B)) |-> (bus_rdata == 8'h00));
  p_hyst_resv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_HYST) |-> (bus_rdata[7:1] == 7'd0));
  p_ctrl_resv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_CTRL) |-> (bus_rdata[7:2] == 6'd0));
endmodule

// File: tb/test_cfg_lock_bank.sv
`timescale 1ns/1ps
module test_cfg_lock_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_rdata, bypass_cfg;
  logic [2:0] slow_smooth;
  logic therm_manual, sync_slave, sync_master, core_low_en, extra_slow;
  logic hyst_disable, run_en, locked;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] m_smooth, m_hyst, m_scr, m_bypass;
  bit m_run, m_lock;

  always #2.5 clk = ~clk;

  cfg_lock_bank i_cfg_lock_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rdata(bus_rdata), .slow_smooth(slow_smooth),
    .therm_manual(therm_manual), .sync_slave(sync_slave), .sync_master(sync_master),
    .core_low_en(core_low_en), .extra_slow(extra_slow), .hyst_disable(hyst_disable),
    .run_en(run_en), .bypass_cfg(bypass_cfg), .locked(locked)
  );

  function automatic logic [7:0] model_read(logic [7:0] a);
    case (a)
      8'h10:   return m_smooth;
      8'h11:   return m_hyst;
      8'h30:   return m_scr;
      8'h40:   return {6'd0, m_lock, m_run};
      8'h7D:   return m_bypass;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_clear();
    m_smooth = 0; m_hyst = 0; m_scr = 0; m_bypass = 0; m_run = 0; m_lock = 0;
  endtask

  task automatic model_write(logic [7:0] a, logic [7:0] d);
    case (a)
      8'h10: if (!m_lock) m_smooth = d;
      8'h11: if (!m_lock) m_hyst = d & 8'h01;
      8'h30: m_scr = d;
      8'h40: begin m_run = d[0]; if (d[1]) m_lock = 1; end
      8'h7D: if (!m_lock) m_bypass = d;
      default: ;
    endcase
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison of all pins against the model
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R8 fields", {extra_slow, core_low_en, sync_master, sync_slave,
                        therm_manual, slow_smooth}, m_smooth);
      chk("R9 hyst_disable", {7'd0, hyst_disable}, {7'd0, m_hyst[0]});
      chk("R9 run_en", {7'd0, run_en}, {7'd0, m_run});
      chk("R9 bypass_cfg", bypass_cfg, m_bypass);
      chk("R4 locked", {7'd0, locked}, {7'd0, m_lock});
      chk("R2 rdata", bus_rdata, model_read(bus_addr));
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; bus_wr = 0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk);
    model_write(a, d);
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    bus_addr = a; bus_wr = 0;
    @(posedge clk);
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    model_clear();
    do_reset();
    // R1: everything zero after reset
    rd(8'h10, 8'h00, "R1 smooth"); rd(8'h11, 8'h00, "R1 hyst");
    rd(8'h30, 8'h00, "R1 scratch"); rd(8'h40, 8'h00, "R1 ctrl");
    rd(8'h7D, 8'h00, "R1 bypass");
    chk("R1 pins", {bypass_cfg}, 8'h00);
    // R2 / R8: write and field decode
    wr(8'h10, 8'hA5); rd(8'h10, 8'hA5, "R2 smooth readback");
    chk("R8 slow_smooth", {5'd0, slow_smooth}, 8'h05);
    chk("R8 master/extra", {6'd0, sync_master, extra_slow}, 8'h03);
    chk("R8 therm/slave/core", {5'd0, therm_manual, sync_slave, core_low_en}, 8'h00);
    wr(8'h10, 8'h5A); rd(8'h10, 8'h5A, "R2 smooth second pattern");
    chk("R8 therm/slave/core", {5'd0, therm_manual, sync_slave, core_low_en}, 8'h07);
    // R7: reserved bits
    wr(8'h11, 8'hFF); rd(8'h11, 8'h01, "R7 hyst mask");
    chk("R9 hyst_disable", {7'd0, hyst_disable}, 8'h01);
    wr(8'h40, 8'hFD); rd(8'h40, 8'h01, "R7 ctrl mask");
    // R6: test and unmapped locations
    wr(8'h7E, 8'hFF); rd(8'h7E, 8'h00, "R6 test A");
    wr(8'h7F, 8'h33); rd(8'h7F, 8'h00, "R6 test B");
    wr(8'h55, 8'hC3); rd(8'h55, 8'h00, "R6 unmapped");
    // R9
    wr(8'h7D, 8'h3C); rd(8'h7D, 8'h3C, "R9 bypass");
    chk("R9 bypass pin", bypass_cfg, 8'h3C);
    wr(8'h30, 8'h11);
    // R4: set lock
    wr(8'h40, 8'h02); rd(8'h40, 8'h02, "R4 lock set");
    chk("R4 locked pin", {7'd0, locked}, 8'h01);
    // R3: lockable writes ignored
    wr(8'h10, 8'hFF); rd(8'h10, 8'h5A, "R3 smooth held");
    wr(8'h11, 8'h00); rd(8'h11, 8'h01, "R3 hyst held");
    wr(8'h7D, 8'h00); rd(8'h7D, 8'h3C, "R3 bypass held");
    chk("R3 bypass pin", bypass_cfg, 8'h3C);
    // R4 / R5: lock cannot be cleared; open registers stay writable
    wr(8'h40, 8'h01); rd(8'h40, 8'h03, "R4 lock sticky R5 run writable");
    wr(8'h30, 8'hEE); rd(8'h30, 8'hEE, "R5 scratch writable");
    // R4: reset clears lock
    do_reset();
    rd(8'h40, 8'h00, "R4 reset clears lock");
    wr(8'h10, 8'h81); rd(8'h10, 8'h81, "R2 write after relock reset");
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule